// File: doc/BRIEF.md
# Dual-Channel Shadowed Configuration Register Bank

This block holds the run-time settings of a two-channel converter behind a byte-wide write/read port addressed by an 8-bit address. Some registers are shared by both channels. The power-mode register exists once per channel. A channel-select register decides which channel copies a write to a per-channel address reaches. Shared registers never consult that selection.

Each settings register has two copies. Writes land in a staging copy. The active copies drive the block's outputs. A single commit write copies every staging value into its active copy on one clock edge, so both channels and the clock settings change together. The shift-order configuration register takes effect as soon as it is written. The same register carries the soft-reset request, which returns every copy to its default. Two read-only identifier addresses return a chip code and a speed-grade code.

Reads are combinational from the address. An address outside the map ignores writes and reads back zero.

Top module: `cfgbank_top`

## Requirements
- R1: After reset, the active outputs are as follows: both channel modes are 00, both pin functions are 0, the divide field is 000 and the stabilizer enable is 1. The bank reads 0x18 at 0x00, 0x03 at 0x05 and 0x00 at 0xFF.
- R2: The configuration register at 0x00 stores the shift-order bit mirrored. A written 1 in bit 6 or bit 1 sets it. The register reads {0, s, 0, 1, 1, 0, s, 0}, and `lsbFirst` follows s on the edge of the write.
- R3: A write to 0x00 with bit 5 or bit 2 set returns every staging copy, active copy, the channel select and s to their reset values on that edge. Afterwards the soft-reset bits read 0.
- R4: Address 0x01 reads the CHIP_ID parameter. Address 0x02 reads the SPEED_GRADE code in bits [6:4] with the other bits 0. Writes to either address change nothing.
- R5: The channel select at 0x05 holds bit 0 for channel A and bit 1 for channel B. Bits [7:2] read 0.
- R6: A write to 0x08 updates the staging power register of every selected channel. Bits [1:0] are the mode (00 normal, 01 full power-down, 10 standby, 11 digital reset). Bit 5 is the external pin function (0 full power-down, 1 standby). The register reads back in the same positions.
- R7: Address 0x09 bit 0 is the stabilizer enable. Address 0x0B bits [2:0] are the divide field, and the divide factor is the field value plus one. Both are written whatever the channel select holds.
- R8: A write to a staging register leaves every output unchanged. A write to 0xFF with bit 0 set copies all staging values to the outputs on that edge. A write to 0xFF with bit 0 clear does nothing.
- R9: Address 0xFF reads 0x01 during the cycle after a commit write and 0x00 from the following edge on.
- R10: A read of 0x08 returns the staging copy of the lowest-numbered selected channel, or 0x00 when no channel is selected.
- R11: A write to an unmapped address changes no register, and a read from it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| chPwrMode | output | 2*NCH | Active mode per channel, channel 0 in bits [1:0] |
| chPinStandby | output | NCH | Active pin function per channel (1 = standby) |
| clkDivSel | output | 3 | Active divide field (factor minus one) |
| dutyStabEn | output | 1 | Active duty-cycle stabilizer enable |
| lsbFirst | output | 1 | Shift-order setting, applied immediately |

## Verification
The first corner case is a per-channel write made while only one channel is selected, and a read made while none is. A design that ignored the select would change both channels, and one that picked the wrong channel would return the other channel's staging value. The bench also checks that staged writes stay off the outputs until a commit, and that a commit write with bit 0 clear does nothing. A bank without proper shadowing would change its outputs early or commit on any write to 0xFF. Soft reset is driven through each nibble's bit separately and inside random traffic. Addresses outside the map are read back to confirm they hold nothing, so a decoder that aliased them onto a real register would show up as soon as one was read.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_CFG   = 8'h00;
  localparam logic [ADDR_W-1:0] A_ID    = 8'h01;
  localparam logic [ADDR_W-1:0] A_GRADE = 8'h02;
  localparam logic [ADDR_W-1:0] A_SEL   = 8'h05;
  localparam logic [ADDR_W-1:0] A_PWR   = 8'h08;
  localparam logic [ADDR_W-1:0] A_CLK   = 8'h09;
  localparam logic [ADDR_W-1:0] A_DIV   = 8'h0B;
  localparam logic [ADDR_W-1:0] A_XFER  = 8'hFF;

  typedef enum logic [3:0] {
    RS_NONE, RS_CFG, RS_ID, RS_GRADE, RS_SEL, RS_PWR, RS_CLK, RS_DIV, RS_XFER
  } rdsel_e;

  typedef struct packed {
    logic   cfgWr;
    logic   softRst;
    logic   selWr;
    logic   pwrWr;
    logic   clkWr;
    logic   divWr;
    logic   xferGo;
    rdsel_e rdSel;
  } strobe_t;

  typedef struct packed {
    logic       pinStandby;
    logic [1:0] mode;
  } pwr_t;

  localparam pwr_t PWR_DEF = '{pinStandby: 1'b0, mode: 2'b00};
  localparam logic DCS_DEF = 1'b1;
  localparam logic [2:0] DIV_DEF = 3'b000;
endpackage

// File: rtl/cfgbank_ctrl.sv
module cfgbank_ctrl
  import cfgbank_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output strobe_t           stb
);
  logic rstReq;
  assign rstReq = wdata[5] | wdata[2];

  always_comb begin
    stb = '0;
    stb.rdSel = RS_NONE;
    unique case (addr)
      A_CFG:   stb.rdSel = RS_CFG;
      A_ID:    stb.rdSel = RS_ID;
      A_GRADE: stb.rdSel = RS_GRADE;
      A_SEL:   stb.rdSel = RS_SEL;
      A_PWR:   stb.rdSel = RS_PWR;
      A_CLK:   stb.rdSel = RS_CLK;
      A_DIV:   stb.rdSel = RS_DIV;
      A_XFER:  stb.rdSel = RS_XFER;
      default: stb.rdSel = RS_NONE;
    endcase
    if (wrEn) begin
      stb.softRst = (addr == A_CFG) && rstReq;
      stb.cfgWr   = (addr == A_CFG) && !rstReq;
      stb.selWr   = (addr == A_SEL);
      stb.pwrWr   = (addr == A_PWR);
      stb.clkWr   = (addr == A_CLK);
      stb.divWr   = (addr == A_DIV);
      stb.xferGo  = (addr == A_XFER) && wdata[0];
    end
  end
endmodule

// File: rtl/cfgbank_dp.sv
module cfgbank_dp
  import cfgbank_pkg::*;
#(
  parameter int NCH = 2,
  parameter logic [7:0] CHIP_ID = 8'h89,
  parameter logic [2:0] SPEED_GRADE = 3'b101
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdData,
  output logic [2*NCH-1:0]  chPwrMode,
  output logic [NCH-1:0]    chPinStandby,
  output logic [2:0]        clkDivSel,
  output logic              dutyStabEn,
  output logic              lsbFirst
);
  localparam logic [NCH-1:0] SEL_DEF = '1;

  logic           lsbQ;
  logic [NCH-1:0] selQ;
  logic           xferQ;
  pwr_t           pwrMst [NCH];
  pwr_t           pwrSlv [NCH];
  logic           dcsMst, dcsSlv;
  logic [2:0]     divMst, divSlv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsbQ  <= 1'b0;
      selQ  <= SEL_DEF;
      xferQ <= 1'b0;
    end else if (stb.softRst) begin
      lsbQ  <= 1'b0;
      selQ  <= SEL_DEF;
      xferQ <= 1'b0;
    end else begin
      if (stb.cfgWr) lsbQ <= wdata[6] | wdata[1];
      if (stb.selWr) selQ <= wdata[NCH-1:0];
      xferQ <= stb.xferGo;
    end
  end

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pwrMst[ch] <= PWR_DEF;
          pwrSlv[ch] <= PWR_DEF;
        end else if (stb.softRst) begin
          pwrMst[ch] <= PWR_DEF;
          pwrSlv[ch] <= PWR_DEF;
        end else begin
          if (stb.pwrWr && selQ[ch]) begin
            pwrMst[ch].mode       <= wdata[1:0];
            pwrMst[ch].pinStandby <= wdata[5];
          end
          if (stb.xferGo) pwrSlv[ch] <= pwrMst[ch];
        end
      end
      assign chPwrMode[2*ch +: 2] = pwrSlv[ch].mode;
      assign chPinStandby[ch]     = pwrSlv[ch].pinStandby;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dcsMst <= DCS_DEF;
      dcsSlv <= DCS_DEF;
      divMst <= DIV_DEF;
      divSlv <= DIV_DEF;
    end else if (stb.softRst) begin
      dcsMst <= DCS_DEF;
      dcsSlv <= DCS_DEF;
      divMst <= DIV_DEF;
      divSlv <= DIV_DEF;
    end else begin
      if (stb.clkWr) dcsMst <= wdata[0];
      if (stb.divWr) divMst <= wdata[2:0];
      if (stb.xferGo) begin
        dcsSlv <= dcsMst;
        divSlv <= divMst;
      end
    end
  end

  // Lowest-numbered selected channel wins the read of the per-channel register.
  pwr_t pwrRd;
  logic pwrHit;
  always_comb begin
    pwrRd  = PWR_DEF;
    pwrHit = 1'b0;
    for (int ch = NCH - 1; ch >= 0; ch--) begin
      if (selQ[ch]) begin
        pwrRd  = pwrMst[ch];
        pwrHit = 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (stb.rdSel)
      RS_CFG:   rdData = {1'b0, lsbQ, 1'b0, 1'b1, 1'b1, 1'b0, lsbQ, 1'b0};
      RS_ID:    rdData = CHIP_ID;
      RS_GRADE: rdData = {1'b0, SPEED_GRADE, 4'b0000};
      RS_SEL:   rdData = {{(DATA_W-NCH){1'b0}}, selQ};
      RS_PWR:   rdData = pwrHit ? {2'b00, pwrRd.pinStandby, 3'b000, pwrRd.mode} : '0;
      RS_CLK:   rdData = {7'b0, dcsMst};
      RS_DIV:   rdData = {5'b0, divMst};
      RS_XFER:  rdData = {7'b0, xferQ};
      default:  rdData = '0;
    endcase
  end

  assign clkDivSel  = divSlv;
  assign dutyStabEn = dcsSlv;
  assign lsbFirst   = lsbQ;
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int NCH = 2,
  parameter logic [7:0] CHIP_ID = 8'h89,
  parameter logic [2:0] SPEED_GRADE = 3'b101
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdData,
  output logic [2*NCH-1:0] chPwrMode,
  output logic [NCH-1:0]   chPinStandby,
  output logic [2:0]       clkDivSel,
  output logic             dutyStabEn,
  output logic             lsbFirst
);
  strobe_t stb;

  cfgbank_ctrl ctrl_i (
    .wrEn (wrEn),
    .addr (addr),
    .wdata(wdata),
    .stb  (stb)
  );

  cfgbank_dp #(
    .NCH(NCH), .CHIP_ID(CHIP_ID), .SPEED_GRADE(SPEED_GRADE)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wdata       (wdata),
    .rdData      (rdData),
    .chPwrMode   (chPwrMode),
    .chPinStandby(chPinStandby),
    .clkDivSel   (clkDivSel),
    .dutyStabEn  (dutyStabEn),
    .lsbFirst    (lsbFirst)
  );
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk #(
  parameter int NCH = 2,
  parameter logic [7:0] CHIP_ID = 8'h89
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [7:0]       addr,
  input logic [7:0]       wdata,
  input logic [7:0]       rdData,
  input logic [2*NCH-1:0] chPwrMode,
  input logic [NCH-1:0]   chPinStandby,
  input logic [2:0]       clkDivSel,
  input logic             dutyStabEn
);
  logic commitWr, softWr, mapped;
  assign commitWr = wrEn && (addr == 8'hFF) && wdata[0];
  assign softWr   = wrEn && (addr == 8'h00) && (wdata[5] || wdata[2]);
  assign mapped   = (addr == 8'h00) || (addr == 8'h01) || (addr == 8'h02) ||
                    (addr == 8'h05) || (addr == 8'h08) || (addr == 8'h09) ||
                    (addr == 8'h0B) || (addr == 8'hFF);

  p_outputs_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(commitWr) && !$past(softWr)) |->
      ($stable(chPwrMode) && $stable(chPinStandby) && $stable(clkDivSel) && $stable(dutyStabEn)));

  p_soft_defaults_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(softWr) |->
      (chPwrMode == '0 && chPinStandby == '0 && clkDivSel == 3'b000 && dutyStabEn));

  p_id_fixed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 8'h01) |-> (rdData == CHIP_ID));

  p_cfg_mirror_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 8'h00) |->
      (rdData[7] == rdData[0] && rdData[6] == rdData[1] &&
       rdData[5] == rdData[2] && rdData[4] == rdData[3]));

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (rdData == 8'h00));

  p_xfer_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((addr == 8'hFF) && !$past(commitWr)) |-> (rdData == 8'h00));
endmodule

bind cfgbank_top cfgbank_chk #(.NCH(NCH), .CHIP_ID(CHIP_ID)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
  .rdData(rdData), .chPwrMode(chPwrMode), .chPinStandby(chPinStandby),
  .clkDivSel(clkDivSel), .dutyStabEn(dutyStabEn)
);

// File: tb/cfgbank_tb.sv
module cfgbank_top_tb_top;
  localparam logic [7:0] CID = 8'h89;
  localparam logic [2:0] GRD = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = 8'h40, wdata = 8'h00, rdData;
  logic [3:0] chPwrMode;
  logic [1:0] chPinStandby;
  logic [2:0] clkDivSel;
  logic dutyStabEn, lsbFirst;

  always #5 clk = ~clk;

  cfgbank_top #(.NCH(2), .CHIP_ID(CID), .SPEED_GRADE(GRD)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdData(rdData), .chPwrMode(chPwrMode), .chPinStandby(chPinStandby),
    .clkDivSel(clkDivSel), .dutyStabEn(dutyStabEn), .lsbFirst(lsbFirst)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // bench model: {pin, mode}
  logic [1:0] mSel;
  logic mLsb, mClkM, mClkS;
  logic [2:0] mPwrM [2], mPwrS [2], mDivM, mDivS;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mSel = 2'b11; mLsb = 0; mClkM = 1; mClkS = 1; mDivM = 0; mDivS = 0;
    for (int c = 0; c < 2; c++) begin mPwrM[c] = 0; mPwrS[c] = 0; end
  endtask

  task automatic modelWrite(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h00: if (d[5] | d[2]) modelReset(); else mLsb = d[6] | d[1];
      8'h05: mSel = d[1:0];
      8'h08: for (int c = 0; c < 2; c++) if (mSel[c]) mPwrM[c] = {d[5], d[1:0]};
      8'h09: mClkM = d[0];
      8'h0B: mDivM = d[2:0];
      8'hFF: if (d[0]) begin
               mPwrS[0] = mPwrM[0]; mPwrS[1] = mPwrM[1]; mClkS = mClkM; mDivS = mDivM;
             end
      default: ;
    endcase
  endtask

  function automatic logic [7:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00: return {1'b0, mLsb, 3'b011, 1'b0, mLsb, 1'b0};
      8'h01: return CID;
      8'h02: return {1'b0, GRD, 4'b0};
      8'h05: return {6'b0, mSel};
      8'h08: begin
        if (mSel[0]) return {2'b0, mPwrM[0][2], 3'b0, mPwrM[0][1:0]};
        if (mSel[1]) return {2'b0, mPwrM[1][2], 3'b0, mPwrM[1][1:0]};
        return 8'h00;
      end
      8'h09: return {7'b0, mClkM};
      8'h0B: return {5'b0, mDivM};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] expOut();
    return {3'b0, mLsb, mClkS, mDivS, mPwrS[1][2], mPwrS[0][2], mPwrS[1][1:0], mPwrS[0][1:0]};
  endfunction

  function automatic logic [15:0] actOut();
    return {3'b0, lsbFirst, dutyStabEn, clkDivSel, chPinStandby, chPwrMode};
  endfunction

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wrEn = 0;
    modelWrite(a, d);
  endtask

  task automatic doRead(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; #1;
    v = rdData;
  endtask

  task automatic readCheck(input logic [7:0] a, input string req);
    logic [7:0] v;
    doRead(a, v);
    check(v == modelRead(a), req, {8'h0, v}, {8'h0, modelRead(a)});
  endtask

  task automatic outCheck(input string req);
    check(actOut() == expOut(), req, actOut(), expOut());
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] addrList [9];
    addrList = '{8'h00, 8'h01, 8'h02, 8'h05, 8'h08, 8'h09, 8'h0B, 8'hFF, 8'h33};
    void'($urandom(32'd12345));
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    outCheck("R1 outputs");
    readCheck(8'h00, "R1 cfg");
    readCheck(8'h05, "R1 select");
    doRead(8'hFF, v); check(v == 8'h00, "R1 xfer", {8'h0, v}, 16'h0);

    // R2 mirrored shift order via either nibble
    doWrite(8'h00, 8'h40);
    check(lsbFirst == 1'b1, "R2 high nibble", {15'h0, lsbFirst}, 16'h1);
    readCheck(8'h00, "R2 readback");
    doWrite(8'h00, 8'h00);
    doWrite(8'h00, 8'h02);
    check(lsbFirst == 1'b1, "R2 low nibble", {15'h0, lsbFirst}, 16'h1);
    doRead(8'h00, v); check(v == 8'h5A, "R2 mirror value", {8'h0, v}, 16'h5A);

    // R4 identifiers are read-only
    doWrite(8'h01, 8'h00);
    doWrite(8'h02, 8'hFF);
    readCheck(8'h01, "R4 chip id");
    readCheck(8'h02, "R4 grade");

    // R5 channel select, upper bits read zero
    doWrite(8'h05, 8'hFE);
    doRead(8'h05, v); check(v == 8'h02, "R5 select", {8'h0, v}, 16'h02);

    // R6/R8 staged write to channel B only, outputs unchanged
    doWrite(8'h08, 8'h23);
    outCheck("R8 staged hold");
    readCheck(8'h08, "R6 staging readback");
    doWrite(8'h05, 8'h01);
    doWrite(8'h08, 8'h02);
    // R8 commit with bit 0 clear does nothing
    doWrite(8'hFF, 8'h00);
    outCheck("R8 no-op commit");
    // R7 shared regs ignore an empty select
    doWrite(8'h05, 8'h00);
    doWrite(8'h09, 8'h00);
    doWrite(8'h0B, 8'h05);
    readCheck(8'h09, "R7 stabilizer staging");
    readCheck(8'h0B, "R7 divide staging");
    // R10 no channel selected
    doRead(8'h08, v); check(v == 8'h00, "R10 empty select", {8'h0, v}, 16'h0);
    // R8/R9 commit and flag pulse
    doWrite(8'hFF, 8'h01);
    outCheck("R8 commit");
    check(chPwrMode == 4'b1110 && chPinStandby == 2'b10, "R6 per-channel codes",
          {10'h0, chPinStandby, chPwrMode}, {10'h0, 2'b10, 4'b1110});
    check(clkDivSel == 3'd5 && !dutyStabEn, "R7 active clock", {12'h0, dutyStabEn, clkDivSel}, 16'h5);
    doRead(8'hFF, v); check(v == 8'h01, "R9 flag set", {8'h0, v}, 16'h1);
    @(posedge clk);
    doRead(8'hFF, v); check(v == 8'h00, "R9 flag clear", {8'h0, v}, 16'h0);
    // R10 both selected -> channel A
    doWrite(8'h05, 8'h03);
    readCheck(8'h08, "R10 lowest channel");
    // R11 unmapped
    doWrite(8'h33, 8'hFF);
    doWrite(8'hFF, 8'h01);
    outCheck("R11 write ignored");
    doRead(8'h33, v); check(v == 8'h00, "R11 read zero", {8'h0, v}, 16'h0);
    // R3 soft reset via each bit
    doWrite(8'h00, 8'h20);
    outCheck("R3 soft reset bit5");
    readCheck(8'h00, "R3 cfg default");
    readCheck(8'h05, "R3 select default");
    doWrite(8'h0B, 8'h07);
    doWrite(8'hFF, 8'h01);
    doWrite(8'h00, 8'h04);
    outCheck("R3 soft reset bit2");
    readCheck(8'h0B, "R3 staging default");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, d, ra;
      a = addrList[$urandom % 9];
      d = 8'($urandom);
      if (a == 8'h00 && ($urandom % 8) != 0) d = d & 8'hDB;
      doWrite(a, d);
      outCheck("R8 random outputs");
      ra = addrList[$urandom % 9];
      if (ra != 8'hFF) readCheck(ra, "R10 random read");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule